// File: doc/BRIEF.md
# Privilege-Checked Address Segment Decoder

This block classifies a 32-bit virtual address for a processor's load, store and fetch path. Each address falls into one of five regions, chosen by its top three bits. The block weighs that region against the current privilege level and the error-level status bit. It then gives one of three outcomes: a physical address formed directly, a request to hand the address to the TLB, or an address error coded by access kind.

A separate mode input selects a fixed-offset mapping for cores that have no TLB. In that mode, every case that would otherwise go to the TLB instead gets a physical address computed by a constant rule. The privilege checks work exactly as they do in normal mode.

One request is accepted per cycle when `req_valid_i` is high. The result appears on the registered outputs one cycle later.

Top module: `seg_xlate`

## Requirements
- R1: With error-level clear and fixed mode off, any address from 0x00000000 to 0x7FFFFFFF gives `tlb_o`=1, `err_o`=0 and `paddr_o`=0, whatever the privilege level.
- R2: With error-level set, an address from 0x00000000 to 0x7FFFFFFF passes through unmapped at any privilege level: `paddr_o`=`vaddr_i`, `tlb_o`=0 and `err_o`=0. This holds in both mapping modes.
- R3: In kernel level, an address from 0x80000000 to 0x9FFFFFFF is unmapped, and `paddr_o`=`vaddr_i`−0x80000000.
- R4: In kernel level, an address from 0xA0000000 to 0xBFFFFFFF is unmapped, and `paddr_o`=`vaddr_i`−0xA0000000.
- R5: At supervisor or user level, any address from 0x80000000 to 0xBFFFFFFF is an address error.
- R6: An address from 0xC0000000 to 0xDFFFFFFF is a TLB request at kernel or supervisor level, and an address error at user level.
- R7: An address from 0xE0000000 to 0xFFFFFFFF is a TLB request at kernel level only, and an address error at every other level.
- R8: Access kind `acc_i` is encoded as 00 load, 01 store, 10 fetch and 11 treated as load. An address error sets `err_o`=10 for a store and `err_o`=01 for every other kind. On an error, `paddr_o`=0 and `tlb_o`=0. A successful access gives `err_o`=00.
- R9: With fixed mode on and error-level clear, an address from 0x00000000 to 0x7FFFFFFF gives `paddr_o`=`vaddr_i`+0x40000000 with `tlb_o`=0.
- R10: With fixed mode on, a permitted address at or above 0xC0000000 gives `paddr_o`=`vaddr_i` with `tlb_o`=0. The privilege checks of R5, R6 and R7 still apply.
- R11: The outputs are registered. A request in cycle n sets `valid_o`=1 in cycle n+1. Without a request, and during reset, all outputs are 0.
- R12: Privilege `priv_i` is encoded as 00 kernel, 01 supervisor, and 10 or 11 user. Both user codes behave identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| vaddr_i | input | 32 | Virtual address |
| priv_i | input | 2 | Privilege level (00 kernel, 01 supervisor, 1x user) |
| erl_i | input | 1 | Error-level status bit |
| acc_i | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 load) |
| fixed_map_i | input | 1 | Fixed-offset mapping mode select |
| valid_o | output | 1 | Result valid |
| paddr_o | output | 32 | Physical address for unmapped or fixed-mapped accesses |
| tlb_o | output | 1 | Address must be translated by the TLB |
| err_o | output | 2 | 00 none, 01 load/fetch address error, 10 store address error |

## Verification
Three controls can act on one request at once: the privilege check, the error-level bypass and the fixed-offset rewrite. Two conflicts matter most. The first is a user-level request to an upper region with fixed mode and error-level both set; the error must win, giving a zero address and no TLB flag. The second is a user-region request with both error-level and fixed mode set; the bypass must win over the +0x40000000 offset. The sweep drives every combination of privilege, error-level, access kind and mode over addresses on each region boundary and over pseudo-random addresses. Each result is compared with a value computed arithmetically in the bench.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_USER = 2'd2,
    PRIV_USR2 = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_LOAD  = 2'd1,
    ERR_STORE = 2'd2,
    ERR_RSVD  = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    RGN_USER  = 3'd0,
    RGN_DIR_C = 3'd1,
    RGN_DIR_U = 3'd2,
    RGN_SUPV  = 3'd3,
    RGN_KERN  = 3'd4
  } region_e;

  typedef struct packed {
    logic allow;
    logic mapped;
  } perm_t;
endpackage

// File: rtl/seg_region_dec.sv
module seg_region_dec
  import seg_xlate_pkg::*;
(
  input  logic [2:0] top_i,
  output region_e    region_o
);
  always_comb begin
    unique casez (top_i)
      3'b0??:  region_o = RGN_USER;
      3'b100:  region_o = RGN_DIR_C;
      3'b101:  region_o = RGN_DIR_U;
      3'b110:  region_o = RGN_SUPV;
      default: region_o = RGN_KERN;
    endcase
  end
endmodule

// File: rtl/seg_priv_chk.sv
module seg_priv_chk
  import seg_xlate_pkg::*;
(
  input  region_e    region_i,
  input  logic [1:0] priv_i,
  input  logic       erl_i,
  output perm_t      perm_o
);
  logic is_kern;
  logic is_supv;

  assign is_kern = (priv_i == PRIV_KERN);
  assign is_supv = (priv_i == PRIV_SUPV);

  always_comb begin
    perm_o = '{allow: 1'b0, mapped: 1'b0};
    unique case (region_i)
      RGN_USER: begin
        perm_o.allow  = 1'b1;
        perm_o.mapped = ~erl_i;
      end
      RGN_DIR_C, RGN_DIR_U: begin
        perm_o.allow  = is_kern;
        perm_o.mapped = 1'b0;
      end
      RGN_SUPV: begin
        perm_o.allow  = is_kern | is_supv;
        perm_o.mapped = 1'b1;
      end
      default: begin
        perm_o.allow  = is_kern;
        perm_o.mapped = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/seg_addr_form.sv
module seg_addr_form
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter bit          FIXED_MAP_EN = 1'b1,
  parameter logic [ADDR_W-1:0] FIX_OFFSET  = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] DIRECT_MASK = 32'h1FFF_FFFF
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  input  region_e           region_i,
  input  logic              mapped_i,
  input  logic              fixed_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              to_tlb_o
);
  logic fixed_eff;

  generate
    if (FIXED_MAP_EN) begin : g_fixed
      assign fixed_eff = fixed_i;
    end else begin : g_nofixed
      assign fixed_eff = fixed_i & 1'b0;
    end
  endgenerate

  always_comb begin
    paddr_o  = '0;
    to_tlb_o = 1'b0;
    if (mapped_i) begin
      if (fixed_eff) begin
        // fixed scheme: user region offset, upper regions identity
        paddr_o = (region_i == RGN_USER) ? (vaddr_i + FIX_OFFSET) : vaddr_i;
      end else begin
        to_tlb_o = 1'b1;
      end
    end else if (region_i == RGN_USER) begin
      paddr_o = vaddr_i;
    end else begin
      paddr_o = vaddr_i & DIRECT_MASK;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter bit          FIXED_MAP_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       vaddr_i,
  input  logic [1:0]        priv_i,
  input  logic              erl_i,
  input  logic [1:0]        acc_i,
  input  logic              fixed_map_i,
  output logic              valid_o,
  output logic [31:0]       paddr_o,
  output logic              tlb_o,
  output logic [1:0]        err_o
);
  localparam int unsigned TOP_LSB = ADDR_W - 3;

  region_e           region;
  perm_t             perm;
  logic [ADDR_W-1:0] paddr_c;
  logic              to_tlb_c;
  logic [1:0]        err_c;

  seg_region_dec u_dec (
    .top_i    (vaddr_i[ADDR_W-1:TOP_LSB]),
    .region_o (region)
  );

  seg_priv_chk u_chk (
    .region_i (region),
    .priv_i   (priv_i),
    .erl_i    (erl_i),
    .perm_o   (perm)
  );

  seg_addr_form #(
    .ADDR_W       (ADDR_W),
    .FIXED_MAP_EN (FIXED_MAP_EN)
  ) u_form (
    .vaddr_i  (vaddr_i),
    .region_i (region),
    .mapped_i (perm.mapped),
    .fixed_i  (fixed_map_i),
    .paddr_o  (paddr_c),
    .to_tlb_o (to_tlb_c)
  );

  always_comb begin
    if (perm.allow)                 err_c = ERR_NONE;
    else if (acc_i == ACC_STORE)    err_c = ERR_STORE;
    else                            err_c = ERR_LOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      paddr_o <= '0;
      tlb_o   <= 1'b0;
      err_o   <= ERR_NONE;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i && perm.allow) begin
        paddr_o <= paddr_c;
        tlb_o   <= to_tlb_c;
        err_o   <= ERR_NONE;
      end else begin
        paddr_o <= '0;
        tlb_o   <= 1'b0;
        err_o   <= req_valid_i ? err_c : ERR_NONE;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] vaddr_i,
  input logic [1:0]  priv_i,
  input logic [1:0]  acc_i,
  input logic        valid_o,
  input logic [31:0] paddr_o,
  input logic        tlb_o,
  input logic [1:0]  err_o
);
  a_r11_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(req_valid_i));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (paddr_o == 32'h0 && !tlb_o && err_o == 2'b00));

  a_r8_tlb_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!(tlb_o && err_o != 2'b00) && err_o != 2'b11));

  a_r8_err_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 2'b00) |-> (paddr_o == 32'h0));

  a_r8_store_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o != 2'b00) |-> ((err_o == 2'b10) == ($past(acc_i) == 2'b01)));

  a_r5_user_upper_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_valid_i) && $past(priv_i[1]) && $past(vaddr_i[31])) |-> (err_o != 2'b00));

  a_r1_low_region_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_valid_i) && !$past(vaddr_i[31])) |-> (err_o == 2'b00));
endmodule

bind seg_xlate seg_xlate_chk u_seg_xlate_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .vaddr_i     (vaddr_i),
  .priv_i      (priv_i),
  .acc_i       (acc_i),
  .valid_o     (valid_o),
  .paddr_o     (paddr_o),
  .tlb_o       (tlb_o),
  .err_o       (err_o)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [1:0]  priv_i = '0;
  logic        erl_i = 1'b0;
  logic [1:0]  acc_i = '0;
  logic        fixed_map_i = 1'b0;
  logic        valid_o;
  logic [31:0] paddr_o;
  logic        tlb_o;
  logic [1:0]  err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  seg_xlate uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .vaddr_i     (vaddr_i),
    .priv_i      (priv_i),
    .erl_i       (erl_i),
    .acc_i       (acc_i),
    .fixed_map_i (fixed_map_i),
    .valid_o     (valid_o),
    .paddr_o     (paddr_o),
    .tlb_o       (tlb_o),
    .err_o       (err_o)
  );

  localparam int NEDGE = 14;
  logic [31:0] edges [NEDGE] = '{
    32'h0000_0000, 32'h1234_5678, 32'h4000_0000, 32'h7FFF_FFFF,
    32'h8000_0000, 32'h9ABC_0000, 32'h9FFF_FFFF, 32'hA000_0000,
    32'hABCD_EF01, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
    32'hE000_0000, 32'hFFFF_FFFF};

  task automatic model(input logic [31:0] a, input logic [1:0] p, input logic e,
                       input logic [1:0] k, input logic f,
                       output logic [31:0] pa, output logic t, output logic [1:0] er,
                       output string tag);
    logic kern, supv, allow, mapped;
    kern = (p == 2'd0);
    supv = (p == 2'd1);
    pa = '0; t = 1'b0; er = 2'd0;
    if (a <= 32'h7FFF_FFFF) begin
      allow = 1'b1; mapped = !e;
    end else if (a <= 32'hBFFF_FFFF) begin
      allow = kern; mapped = 1'b0;
    end else if (a <= 32'hDFFF_FFFF) begin
      allow = kern || supv; mapped = 1'b1;
    end else begin
      allow = kern; mapped = 1'b1;
    end
    if (!allow) begin
      er = (k == 2'd1) ? 2'd2 : 2'd1;
      if (a <= 32'hBFFF_FFFF)      tag = "R5 R8";
      else if (a <= 32'hDFFF_FFFF) tag = "R6 R8";
      else                         tag = "R7 R8";
    end else if (mapped) begin
      if (f) begin
        if (a <= 32'h7FFF_FFFF) begin pa = a + 32'h4000_0000; tag = "R9"; end
        else begin pa = a; tag = "R10"; end
      end else begin
        t = 1'b1;
        if (a <= 32'h7FFF_FFFF)      tag = "R1";
        else if (a <= 32'hDFFF_FFFF) tag = "R6";
        else                         tag = "R7";
      end
    end else begin
      if (a <= 32'h7FFF_FFFF)      begin pa = a; tag = "R2"; end
      else if (a <= 32'h9FFF_FFFF) begin pa = a - 32'h8000_0000; tag = "R3"; end
      else                         begin pa = a - 32'hA000_0000; tag = "R4"; end
    end
    if (p == 2'd3) tag = {tag, " R12"};
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] p, input logic e,
                       input logic [1:0] k, input logic f);
    logic [31:0] pa; logic t; logic [1:0] er; string tag;
    model(a, p, e, k, f, pa, t, er, tag);
    req_valid_i = 1'b1; vaddr_i = a; priv_i = p; erl_i = e; acc_i = k; fixed_map_i = f;
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b1 || paddr_o !== pa || tlb_o !== t || err_o !== er) begin
      n_fail++;
      $display("FAIL %s a=%h p=%0d e=%0d k=%0d f=%0d got v=%0d pa=%h t=%0d er=%0d exp v=1 pa=%h t=%0d er=%0d",
               tag, a, p, e, k, f, valid_o, paddr_o, tlb_o, er === er ? err_o : err_o, pa, t, er);
    end
  endtask

  task automatic check_idle(input string what);
    n_chk++;
    if (valid_o !== 1'b0 || paddr_o !== 32'h0 || tlb_o !== 1'b0 || err_o !== 2'd0) begin
      n_fail++;
      $display("FAIL R11 %s got v=%0d pa=%h t=%0d er=%0d exp all zero",
               what, valid_o, paddr_o, tlb_o, err_o);
    end
  endtask

  task automatic sweep(input logic [31:0] a);
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 4; k++)
          for (int f = 0; f < 2; f++)
            apply(a, 2'(p), 1'(e), 2'(k), 1'(f));
  endtask

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1357_9BDF;
    @(negedge clk_i);
    check_idle("in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("after reset, no request");
    for (int i = 0; i < NEDGE; i++) sweep(edges[i]);
    for (int i = 0; i < 48; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      sweep(lcg);
    end
    // request dropped: R11 outputs clear next cycle
    req_valid_i = 1'b0;
    vaddr_i = 32'hFFFF_FFFF; priv_i = 2'd2; acc_i = 2'd1;
    @(negedge clk_i);
    check_idle("request dropped");
    @(negedge clk_i);
    check_idle("idle with error-causing inputs");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired R11 got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule